// File: doc/BRIEF.md
# Framed Byte-Stream Register Command Engine

This block sits behind a byte-oriented serial receiver and turns framed binary commands into accesses on an internal 32-bit register bus. A command frame opens with the marker byte 0x55, carries a command code, and closes with 0xAA. Write and read frames also carry a 16-bit register address. This address is split into a core prefix byte and a register index byte. A write frame also carries four data bytes. Each accepted command produces exactly one bus transfer, or none for control frames. It also produces one framed response. Response frames use the swapped markers: they open with 0xAA and close with 0x55.

Bytes come in and go out over valid/ready handshakes. While a command is on the bus, or its response is still draining, the input side holds off, so commands never overlap. Stray bytes seen between frames are consumed and dropped. A wrong code byte yields an "unknown" response. A wrong byte where the closing marker belongs yields an "error" response. In both cases the response quotes the offending byte.

Top module: `frame_cmd_engine`

## Requirements
- R1: While waiting for a frame start, every input byte other than 0x55 is accepted (in_ready high) and dropped, with no output byte and no bus request.
- R2: The write frame 55 11 P I D3 D2 D1 D0 AA causes one bus request with bus_we=1, bus_addr={P,I} and bus_wdata={D3,D2,D1,D0} (the first data byte is bits 31:24). After bus_ack it returns AA 7E P I 55.
- R3: The read frame 55 10 P I AA causes one bus request with bus_we=0 and bus_addr={P,I}. bus_rdata is captured on bus_ack, and the response is AA 7F P I followed by the data most significant byte first, then 55.
- R4: The reset frame 55 01 AA returns AA 7D 55 and makes no bus request.
- R5: Any code byte other than 0x10, 0x11 or 0x01 returns AA FE <code> 55 at once. There is no bus request, and the parser goes back to waiting for a start byte.
- R6: If the byte in the closing-marker position (the 9th byte of a write, the 5th of a read, the 3rd of a reset) is not 0xAA, the response is AA FD <that byte> 55. There is no bus request, and the parser goes back to waiting for a start byte.
- R7: in_ready is low from the closing byte of a command until the last byte of its response is taken. A byte offered in that window is held and accepted afterwards.
- R8: bus_req is high for exactly one cycle per bus command. bus_ack is only honoured in the cycles after that one, and no response byte is offered before it.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R10: After reset, in_ready is high and out_valid and bus_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received command byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Engine can take a byte |
| out_data | output | 8 | Response byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Consumer takes the response byte |
| bus_req | output | 1 | One-cycle register bus request |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 16 | Prefix (high byte) and register index (low byte) |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus transfer complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
Two events can fall in the same cycle: the consumer takes the last byte of a response, and the producer offers the start byte of the next command. The bench provokes this by sending two commands back to back while the response side is throttled at random. The second start byte is therefore offered throughout the first response. The bench judges the result in two ways. First, in_ready must never be high in a cycle where out_valid is high. Second, both responses must arrive whole and in order. A second overlap, bus_ack raised in the same cycle as bus_req with wrong data, must be ignored in favour of the later acknowledge.

// File: rtl/frame_cmd_engine.sv
module frame_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        bus_req,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);
  localparam logic [7:0] CMD_SOF = 8'h55, CMD_EOF = 8'hAA;
  localparam logic [7:0] RSP_SOF = 8'hAA, RSP_EOF = 8'h55;
  localparam logic [7:0] OP_WR = 8'h11, OP_RD = 8'h10, OP_RST = 8'h01;
  localparam logic [7:0] AK_WR = 8'h7E, AK_RD = 8'h7F, AK_RST = 8'h7D;
  localparam logic [7:0] NK_UNK = 8'hFE, NK_ERR = 8'hFD;

  typedef enum logic [2:0] {S_IDLE, S_CODE, S_BODY, S_BUS, S_WAIT, S_RESP} state_t;
  typedef enum logic [2:0] {K_WR, K_RD, K_RST, K_UNK, K_ERR} kind_t;

  state_t      state;
  kind_t       kind;
  logic [7:0]  op, pfx, ridx, bad;
  logic [31:0] wdata, rdata;
  logic [2:0]  cnt;
  logic [3:0]  ocnt;
  logic [2:0]  end_pos;
  logic [3:0]  olen;
  logic [7:0]  rcode;
  logic        in_fire;

  assign in_ready  = (state == S_IDLE) || (state == S_CODE) || (state == S_BODY);
  assign in_fire   = in_valid && in_ready;
  assign out_valid = (state == S_RESP);
  assign bus_req   = (state == S_BUS);
  assign bus_we    = (op == OP_WR);
  assign bus_addr  = {pfx, ridx};
  assign bus_wdata = wdata;

  assign end_pos = (op == OP_WR) ? 3'd6 : (op == OP_RD) ? 3'd2 : 3'd0;

  always_comb begin
    case (kind)
      K_WR:    begin olen = 4'd5; rcode = AK_WR;  end
      K_RD:    begin olen = 4'd9; rcode = AK_RD;  end
      K_RST:   begin olen = 4'd3; rcode = AK_RST; end
      K_UNK:   begin olen = 4'd4; rcode = NK_UNK; end
      default: begin olen = 4'd4; rcode = NK_ERR; end
    endcase
  end

  always_comb begin
    if (ocnt == 4'd0)                         out_data = RSP_SOF;
    else if (ocnt == olen - 4'd1)             out_data = RSP_EOF;
    else if (ocnt == 4'd1)                    out_data = rcode;
    else if (kind == K_UNK || kind == K_ERR)  out_data = bad;
    else begin
      case (ocnt)
        4'd2:    out_data = pfx;
        4'd3:    out_data = ridx;
        4'd4:    out_data = rdata[31:24];
        4'd5:    out_data = rdata[23:16];
        4'd6:    out_data = rdata[15:8];
        default: out_data = rdata[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      kind  <= K_WR;
      op    <= 8'h00;
      pfx   <= 8'h00;
      ridx  <= 8'h00;
      bad   <= 8'h00;
      wdata <= 32'h0;
      rdata <= 32'h0;
      cnt   <= 3'd0;
      ocnt  <= 4'd0;
    end else begin
      case (state)
        S_IDLE: if (in_fire && in_data == CMD_SOF) state <= S_CODE;
        S_CODE: if (in_fire) begin
          op  <= in_data;
          cnt <= 3'd0;
          if (in_data == OP_WR || in_data == OP_RD || in_data == OP_RST)
            state <= S_BODY;
          else begin
            kind  <= K_UNK;
            bad   <= in_data;
            state <= S_RESP;
          end
        end
        S_BODY: if (in_fire) begin
          if (cnt == end_pos) begin
            if (in_data != CMD_EOF) begin
              kind  <= K_ERR;
              bad   <= in_data;
              state <= S_RESP;
            end else if (op == OP_RST) begin
              kind  <= K_RST;
              state <= S_RESP;
            end else
              state <= S_BUS;
          end else begin
            case (cnt)
              3'd0:    pfx   <= in_data;
              3'd1:    ridx  <= in_data;
              default: wdata <= {wdata[23:0], in_data};
            endcase
            cnt <= cnt + 3'd1;
          end
        end
        S_BUS: state <= S_WAIT;
        S_WAIT: if (bus_ack) begin
          if (op == OP_RD) begin
            rdata <= bus_rdata;
            kind  <= K_RD;
          end else
            kind  <= K_WR;
          state <= S_RESP;
        end
        S_RESP: if (out_ready) begin
          if (ocnt == olen - 4'd1) begin
            ocnt  <= 4'd0;
            state <= S_IDLE;
          end else
            ocnt <= ocnt + 4'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_cmd_engine_chk.sv
module frame_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic [7:0]  out_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic        bus_req
);
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r8_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  a_r8_quiet_during_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !out_valid && !in_ready);

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r2_frame_opens: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_data == 8'hAA);
endmodule

bind frame_cmd_engine frame_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .bus_req(bus_req)
);

// File: tb/frame_cmd_engine_tb.sv
module frame_cmd_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = 32'h0;

  always #5 clk = ~clk;

  frame_cmd_engine u_dut (.*);

  typedef struct packed {
    logic [3:0]  tag;
    logic [71:0] cmd;
    logic [3:0]  clen;
    logic [71:0] rsp;
    logic [3:0]  rlen;
    logic        bus;
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R2 write
    '{4'd2, 72'h55_11_12_34_DE_AD_BE_EF_AA, 4'd9, 72'hAA_7E_12_34_55_00_00_00_00, 4'd5, 1'b1, 1'b1, 16'h1234, 32'hDEADBEEF, 32'h0},
    // R3 read
    '{4'd3, 72'h55_10_20_08_AA_00_00_00_00, 4'd5, 72'hAA_7F_20_08_CA_FE_F0_0D_55, 4'd9, 1'b1, 1'b0, 16'h2008, 32'h0, 32'hCAFEF00D},
    // R4 reset
    '{4'd4, 72'h55_01_AA_00_00_00_00_00_00, 4'd3, 72'hAA_7D_55_00_00_00_00_00_00, 4'd3, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0},
    // R5 unknown code
    '{4'd5, 72'h55_42_00_00_00_00_00_00_00, 4'd2, 72'hAA_FE_42_55_00_00_00_00_00, 4'd4, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0},
    // R6 bad closing byte on a read
    '{4'd6, 72'h55_10_01_02_33_00_00_00_00, 4'd5, 72'hAA_FD_33_55_00_00_00_00_00, 4'd4, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0},
    // R6 bad closing byte on a write
    '{4'd6, 72'h55_11_AB_CD_01_02_03_04_77, 4'd9, 72'hAA_FD_77_55_00_00_00_00_00, 4'd4, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0},
    // R6 bad closing byte on a reset
    '{4'd6, 72'h55_01_00_00_00_00_00_00_00, 4'd3, 72'hAA_FD_00_55_00_00_00_00_00, 4'd4, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0},
    // R1 stray bytes before a read
    '{4'd1, 72'h00_AA_13_55_10_FF_00_AA_00, 4'd8, 72'hAA_7F_FF_00_00_00_00_01_55, 4'd9, 1'b1, 1'b0, 16'hFF00, 32'h0, 32'h00000001},
    // R2 marker values inside write data
    '{4'd2, 72'h55_11_00_01_55_AA_55_AA_AA, 4'd9, 72'hAA_7E_00_01_55_00_00_00_00, 4'd5, 1'b1, 1'b1, 16'h0001, 32'h55AA55AA, 32'h0}
  };

  int n_chk = 0, n_fail = 0;
  int rx_cnt = 0, overlap = 0, hold_bad = 0, bus_cnt = 0, req_run = 0, req_max = 0;
  logic [7:0]  rx [0:31];
  logic [7:0]  lfsr = 8'h5A;
  logic        bp = 1'b0, early = 1'b0;
  logic        stall_prev = 1'b0;
  logic [7:0]  stall_data = 8'h00;
  logic        last_we = 1'b0;
  logic [15:0] last_addr = 16'h0;
  logic [31:0] last_wdata = 32'h0, next_rd = 32'h0;
  int          ack_delay = 1, ack_timer = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp ? lfsr[0] : 1'b1;
    if (rst_n) begin
      if (in_ready && out_valid) overlap++;
      if (stall_prev && (!out_valid || out_data != stall_data)) hold_bad++;
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready) begin
        rx[rx_cnt[4:0]] = out_data;
        rx_cnt++;
      end
      if (bus_req) req_run++; else req_run = 0;
      if (req_run > req_max) req_max = req_run;
    end
  end

  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (ack_timer != 0) begin
      ack_timer--;
      if (ack_timer == 0) begin
        bus_ack = 1'b1;
        bus_rdata = next_rd;
      end
    end
    if (rst_n && bus_req) begin
      bus_cnt++;
      last_we = bus_we;
      last_addr = bus_addr;
      last_wdata = bus_wdata;
      ack_timer = ack_delay;
      if (early) begin
        bus_ack = 1'b1;
        bus_rdata = 32'hBAD0BAD0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 80'h0, 80'h1);
    finish_run();
  end

  task automatic send_byte(input logic [7:0] b);
    in_data = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [71:0] f, input int n);
    for (int i = 0; i < n; i++) send_byte(f[71 - 8*i -: 8]);
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 400 && rx_cnt < n; i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [71:0] rx_packed();
    logic [71:0] v = '0;
    for (int i = 0; i < 9; i++) if (i < rx_cnt) v[71 - 8*i -: 8] = rx[i];
    return v;
  endfunction

  initial begin
    logic [71:0] act;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(in_ready && !out_valid && !bus_req, "R10", "reset outputs",
          {77'h0, in_ready, out_valid, bus_req}, 80'h4);

    // R1 stray bytes alone
    rx_cnt = 0; bus_cnt = 0;
    send_byte(8'h00); send_byte(8'hFF); send_byte(8'hAA); send_byte(8'h11);
    repeat (20) @(negedge clk);
    check(rx_cnt == 0 && bus_cnt == 0 && in_ready, "R1", "stray bytes dropped",
          {16'h0, 32'(rx_cnt), 32'(bus_cnt)}, 80'h0);

    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = $sformatf("R%0d", VECS[v].tag);
      rx_cnt = 0; bus_cnt = 0;
      next_rd = VECS[v].rd;
      send_frame(VECS[v].cmd, int'(VECS[v].clen));
      wait_rx(int'(VECS[v].rlen));
      act = rx_packed();
      check(rx_cnt == int'(VECS[v].rlen) && act == VECS[v].rsp, tg,
            $sformatf("vector %0d response", v), {4'(rx_cnt), 4'h0, act},
            {VECS[v].rlen, 4'h0, VECS[v].rsp});
      check(bus_cnt == int'(VECS[v].bus) &&
            (!VECS[v].bus || (last_we == VECS[v].we && last_addr == VECS[v].addr &&
                              (!VECS[v].we || last_wdata == VECS[v].wdata))),
            tg, $sformatf("vector %0d bus", v),
            {8'(bus_cnt), 7'h0, last_we, last_addr, last_wdata, 16'h0},
            {7'h0, VECS[v].bus, 7'h0, VECS[v].we, VECS[v].addr, VECS[v].wdata, 16'h0});
    end

    // R7 / R9 back-to-back commands under random backpressure
    bp = 1'b1; rx_cnt = 0; overlap = 0; hold_bad = 0; ack_delay = 3;
    send_frame(72'h55_11_12_34_00_00_00_01_AA, 9);
    send_frame(72'h55_01_AA_00_00_00_00_00_00, 3);
    wait_rx(8);
    act = rx_packed();
    check(rx_cnt == 8 && act[71:8] == 64'hAA_7E_12_34_55_AA_7D_55, "R7",
          "queued command responses", {8'(rx_cnt), act}, {8'd8, 64'hAA_7E_12_34_55_AA_7D_55, 8'h0});
    check(overlap == 0, "R7", "in_ready during response", 80'(overlap), 80'h0);

    // R9 read under backpressure, then hold check
    rx_cnt = 0; next_rd = 32'h89ABCDEF;
    send_frame(72'h55_10_0F_F0_AA_00_00_00_00, 5);
    wait_rx(9);
    act = rx_packed();
    check(act == 72'hAA_7F_0F_F0_89_AB_CD_EF_55, "R9", "stalled read response",
          {8'h0, act}, {8'h0, 72'hAA_7F_0F_F0_89_AB_CD_EF_55});
    check(hold_bad == 0, "R9", "output held while stalled", 80'(hold_bad), 80'h0);
    bp = 1'b0;

    // R8 acknowledge in the request cycle is ignored
    rx_cnt = 0; bus_cnt = 0; req_max = 0; early = 1'b1; ack_delay = 5;
    next_rd = 32'h11223344;
    send_frame(72'h55_10_AB_CD_AA_00_00_00_00, 5);
    wait_rx(9);
    early = 1'b0;
    act = rx_packed();
    check(act == 72'hAA_7F_AB_CD_11_22_33_44_55, "R8", "early ack ignored",
          {8'h0, act}, {8'h0, 72'hAA_7F_AB_CD_11_22_33_44_55});
    check(req_max == 1 && bus_cnt == 1, "R8", "single request cycle",
          {16'h0, 32'(req_max), 32'(bus_cnt)}, {16'h0, 32'd1, 32'd1});

    finish_run();
  end
endmodule